// File: doc/BRIEF.md
# TDM Slot-Masked Serial Transmitter

This block turns a stream of parallel audio samples into one serial data line carrying a time-division multiplexed frame. A timing generator supplies a one-cycle bit enable for each bit period and a frame-start pulse. The block counts a configurable lead-in of bit periods, then walks through a configurable number of equal-width slots. In each slot that its transmit mask enables, it pulls one sample from an upstream ready/valid stream and shifts it out most significant bit first. Slot bits beyond the sample length, the lead-in, masked slots, slots with no sample ready, and the tail after the last slot all carry zeros.

The sample length comes from a coded 3-bit field. A mask request wider than the slot count is saturated, so any request above the largest legal mask enables every slot. A loopback switch hands the transmitted line to a paired receiver in place of the external receive pin. A sticky flag records any enabled slot that found the stream empty.

Top module: `tdm_slot_tx`

## Requirements
- R1: After a synchronous active-low reset, `sdata`, `in_ready` and `underflow` are 0.
- R2: The bit period that carries the `frame_start` pulse is bit position 0 of the frame. The first bit of slot 0 is output in position `cfg_offset`, so an offset of 0 puts it in the pulse period itself. All lead-in positions carry 0.
- R3: A frame holds `cfg_slots_m1`+1 slots, each of `cfg_slot_bits_m1`+1 bit periods, with slot n following slot n-1. After the last slot, `sdata` stays 0 until the next `frame_start`.
- R4: The sample is taken from the low bits of `in_data`. Its length is 4*(`cfg_size_code`+1) bits, so codes 1, 3 and 7 give 8, 16 and 32 bits. It is sent MSB first from the first bit of the slot. Slot bits past the sample length are 0.
- R5: Slot n is enabled by bit n of the effective mask. A disabled slot outputs 0 and does not raise `in_ready`, so it consumes no sample.
- R6: If `cfg_mask_req` has any bit set above bit 15, the effective mask is 0xFFFF. Otherwise the effective mask is `cfg_mask_req[15:0]`.
- R7: `in_ready` is 1 exactly in the `bit_en` cycle that begins an enabled slot. A sample transfers when `in_valid` is also 1 in that cycle.
- R8: If `in_valid` is 0 when an enabled slot begins, the whole slot is sent as 0 and `underflow` becomes 1 and stays 1 until reset.
- R9: `rx_data` equals `sdata` while `cfg_loopback` is 1, and equals `rx_pin` while it is 0.
- R10: `sdata` and `underflow` change only on clock edges where `bit_en` is 1. A `frame_start` pulse without `bit_en` is ignored.
- R11: A `frame_start` pulse in the middle of a frame restarts the frame at position 0. The rest of the old frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle enable per bit period |
| frame_start | input | 1 | Marks bit position 0 of a frame (sampled with bit_en) |
| cfg_slots_m1 | input | 4 | Slots per frame minus one |
| cfg_slot_bits_m1 | input | 6 | Bit periods per slot minus one |
| cfg_size_code | input | 3 | Coded sample length: 1=8, 3=16, 7=32 bits |
| cfg_offset | input | 11 | Bit periods from frame start to first data bit |
| cfg_mask_req | input | 32 | Requested transmit slot mask, saturated to 16 bits |
| cfg_loopback | input | 1 | Routes the transmitted line to rx_data |
| in_valid | input | 1 | Upstream sample available |
| in_ready | output | 1 | Block takes a sample this cycle |
| in_data | input | 32 | Upstream sample, right-aligned |
| sdata | output | 1 | Serial data line |
| rx_pin | input | 1 | External receive line |
| rx_data | output | 1 | Receive line for the paired deserializer |
| underflow | output | 1 | Sticky: an enabled slot found no sample |

## Verification
A `frame_start` restart can land in the same bit period that would have opened an enabled slot of the old frame. With a zero offset, that same period also opens slot 0 of the new frame, so a sample request and a restart fall on one edge. The bench issues such a restart exactly on a slot boundary while the stream is intermittently empty. It judges `in_ready`, each serial bit and the underflow flag against a behavioural frame model that knows only positions and slot numbers. Stray frame-start pulses between bit enables and a saturated mask request are mixed into the same runs.

// File: rtl/tdm_tx_pkg.sv
// Package: shared types for the TDM slot transmitter.
package tdm_tx_pkg;
    // Frame progress of the transmitter
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no frame seen since reset
        PH_LEAD = 2'd1,   // counting lead-in bits before slot 0
        PH_DATA = 2'd2,   // inside a slot
        PH_DONE = 2'd3    // past the last slot, waiting for next frame
    } tx_phase_e;
endpackage

// File: rtl/tdm_frame_ctr.sv
// Frame position counter.
// Tracks lead-in, slot number and bit-in-slot for the bit period that is
// about to be transmitted. The cur_* outputs describe that next position
// and are meaningful only while bit_en is high. Assumes the configuration
// is held steady during a frame.
module tdm_frame_ctr
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_MAX      = 16,
    parameter int SLOT_BITS_MAX = 64,
    parameter int OFFSET_W      = 11,
    localparam int SLOT_IW      = $clog2(SLOT_MAX),
    localparam int BIT_IW       = $clog2(SLOT_BITS_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                frame_start,
    input  logic [SLOT_IW-1:0]  cfg_slots_m1,
    input  logic [BIT_IW-1:0]   cfg_slot_bits_m1,
    input  logic [OFFSET_W-1:0] cfg_offset,
    output logic                cur_data,
    output logic [SLOT_IW-1:0]  cur_slot,
    output logic                slot_first
);
    tx_phase_e           ph_q,   n_ph;
    logic [OFFSET_W-1:0] lead_q, n_lead;
    logic [BIT_IW-1:0]   bit_q,  n_bit;
    logic [SLOT_IW-1:0]  slot_q, n_slot;

    // Next frame position from the current one or a frame restart
    always_comb begin
        n_ph   = ph_q;
        n_lead = lead_q;
        n_bit  = bit_q;
        n_slot = slot_q;
        if (frame_start) begin
            n_bit  = '0;
            n_slot = '0;
            if (cfg_offset == '0) begin
                n_ph = PH_DATA;
            end else begin
                n_ph   = PH_LEAD;
                n_lead = cfg_offset - OFFSET_W'(1);
            end
        end else begin
            case (ph_q)
                PH_LEAD: begin
                    if (lead_q == '0) begin
                        n_ph   = PH_DATA;
                        n_bit  = '0;
                        n_slot = '0;
                    end else begin
                        n_lead = lead_q - OFFSET_W'(1);
                    end
                end
                PH_DATA: begin
                    if (bit_q == cfg_slot_bits_m1) begin
                        n_bit = '0;
                        if (slot_q == cfg_slots_m1) n_ph = PH_DONE;
                        else                        n_slot = slot_q + SLOT_IW'(1);
                    end else begin
                        n_bit = bit_q + BIT_IW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Advance the position once per bit period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            lead_q <= '0;
            bit_q  <= '0;
            slot_q <= '0;
        end else if (bit_en) begin
            ph_q   <= n_ph;
            lead_q <= n_lead;
            bit_q  <= n_bit;
            slot_q <= n_slot;
        end
    end

    // Decode of the position being transmitted
    always_comb begin
        cur_data   = (n_ph == PH_DATA);
        cur_slot   = n_slot;
        slot_first = (n_ph == PH_DATA) && (n_bit == '0);
    end

    // R3
    bit_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_q == PH_DATA) && $stable(cfg_slot_bits_m1)) |-> (bit_q <= cfg_slot_bits_m1));
    // R3
    slot_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_q == PH_DATA) && $stable(cfg_slots_m1)) |-> (slot_q <= cfg_slots_m1));
endmodule

// File: rtl/tdm_slot_shifter.sv
// Slot serializer.
// At the first bit of an enabled slot it takes one sample from the upstream
// stream, left-aligns it by the coded sample length and shifts it out MSB
// first; zeros follow once the sample is spent. Disabled slots, idle
// positions and starved slots send zeros. Assumes slot_on/slot_first come
// from the frame counter for the bit being transmitted.
module tdm_slot_shifter #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                slot_on,
    input  logic                slot_first,
    input  logic [2:0]          size_code,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                in_ready,
    output logic                sdata,
    output logic                underflow
);
    logic [SAMPLE_W-1:0] sh_q;
    logic [SAMPLE_W-1:0] aligned;
    logic [7:0]          sbits;
    int unsigned         lshift;

    // Handshake: one request per enabled slot, at its first bit
    always_comb in_ready = bit_en && slot_on && slot_first;

    // Left-align the right-justified sample so its MSB sits on top
    always_comb begin
        sbits  = 8'((int'(size_code) + 1) * 4);
        lshift = (int'(sbits) >= SAMPLE_W) ? 0 : SAMPLE_W - int'(sbits);
        aligned = in_data << lshift;
    end

    // Shift register, serial output and sticky starvation flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sdata     <= 1'b0;
            underflow <= 1'b0;
        end else if (bit_en) begin
            if (!slot_on) begin
                sh_q  <= '0;
                sdata <= 1'b0;
            end else if (slot_first) begin
                if (in_valid) begin
                    sdata <= aligned[SAMPLE_W-1];
                    sh_q  <= aligned << 1;
                end else begin
                    sdata     <= 1'b0;
                    sh_q      <= '0;
                    underflow <= 1'b1;
                end
            end else begin
                sdata <= sh_q[SAMPLE_W-1];
                sh_q  <= sh_q << 1;
            end
        end
    end

    // R5
    zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !slot_on) |=> !sdata);
    // R8
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    // R8
    underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (underflow && !sdata));
    // R10
    quiet_between_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sdata) && $stable(underflow)));
endmodule

// File: rtl/tdm_slot_tx.sv
// TDM slot-masked serial transmitter, top level.
// Saturates the requested mask to the slot count, ties the frame counter
// to the slot serializer and selects the receive line for the paired
// deserializer. Assumes bit_en and frame_start come from one timing source.
module tdm_slot_tx #(
    parameter int SLOT_MAX      = 16,
    parameter int SLOT_BITS_MAX = 64,
    parameter int OFFSET_W      = 11,
    parameter int SAMPLE_W      = 32,
    parameter int MASK_REQ_W    = 32,
    localparam int SLOT_IW      = $clog2(SLOT_MAX),
    localparam int BIT_IW       = $clog2(SLOT_BITS_MAX)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  frame_start,
    input  logic [SLOT_IW-1:0]    cfg_slots_m1,
    input  logic [BIT_IW-1:0]     cfg_slot_bits_m1,
    input  logic [2:0]            cfg_size_code,
    input  logic [OFFSET_W-1:0]   cfg_offset,
    input  logic [MASK_REQ_W-1:0] cfg_mask_req,
    input  logic                  cfg_loopback,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [SAMPLE_W-1:0]   in_data,
    output logic                  sdata,
    input  logic                  rx_pin,
    output logic                  rx_data,
    output logic                  underflow
);
    logic [SLOT_MAX-1:0] mask_eff;
    logic                cur_data;
    logic [SLOT_IW-1:0]  cur_slot;
    logic                slot_first;
    logic                slot_on;

    // Saturate an oversized mask request to all slots enabled
    generate
        if (MASK_REQ_W > SLOT_MAX) begin : g_mask_clamp
            assign mask_eff = (|cfg_mask_req[MASK_REQ_W-1:SLOT_MAX]) ? '1
                                                                     : cfg_mask_req[SLOT_MAX-1:0];
        end else begin : g_mask_pass
            assign mask_eff = SLOT_MAX'(cfg_mask_req);
        end
    endgenerate

    tdm_frame_ctr #(
        .SLOT_MAX      (SLOT_MAX),
        .SLOT_BITS_MAX (SLOT_BITS_MAX),
        .OFFSET_W      (OFFSET_W)
    ) u_ctr (
        .clk              (clk),
        .rst_n            (rst_n),
        .bit_en           (bit_en),
        .frame_start      (frame_start),
        .cfg_slots_m1     (cfg_slots_m1),
        .cfg_slot_bits_m1 (cfg_slot_bits_m1),
        .cfg_offset       (cfg_offset),
        .cur_data         (cur_data),
        .cur_slot         (cur_slot),
        .slot_first       (slot_first)
    );

    // Slot carries data only when inside the frame and mask-enabled
    always_comb slot_on = cur_data && mask_eff[cur_slot];

    tdm_slot_shifter #(
        .SAMPLE_W (SAMPLE_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .slot_on    (slot_on),
        .slot_first (slot_first),
        .size_code  (cfg_size_code),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .sdata      (sdata),
        .underflow  (underflow)
    );

    // Receive line: own transmit data in loopback, external pin otherwise
    always_comb rx_data = cfg_loopback ? sdata : rx_pin;

    // R7
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (bit_en && cur_data));
endmodule

// File: tb/tdm_slot_tx_tb.sv
// Bench for tdm_slot_tx: behavioural frame model compared every cycle.
module tdm_slot_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        frame_start = 1'b0;
    logic [3:0]  cfg_slots_m1 = '0;
    logic [5:0]  cfg_slot_bits_m1 = '0;
    logic [2:0]  cfg_size_code = '0;
    logic [10:0] cfg_offset = '0;
    logic [31:0] cfg_mask_req = '0;
    logic        cfg_loopback = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        sdata;
    logic        rx_pin = 1'b0;
    logic        rx_data;
    logic        underflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int          pos = -1;
    bit          have = 0;
    logic [31:0] cur = '0;
    bit          uf_exp = 0;
    bit          exp_sd = 0;
    int          gcyc = 0;
    logic [31:0] rnd = 32'h1234_5678;

    always #2 clk = ~clk;

    tdm_slot_tx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
        .cfg_slots_m1(cfg_slots_m1), .cfg_slot_bits_m1(cfg_slot_bits_m1),
        .cfg_size_code(cfg_size_code), .cfg_offset(cfg_offset),
        .cfg_mask_req(cfg_mask_req), .cfg_loopback(cfg_loopback),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .sdata(sdata), .rx_pin(rx_pin), .rx_data(rx_data), .underflow(underflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at pos %0d: actual %0d expected %0d", req, pos, act, exp);
        end
    endtask

    function automatic logic [15:0] eff_mask();
        return (|cfg_mask_req[31:16]) ? 16'hFFFF : cfg_mask_req[15:0];
    endfunction

    // One clock cycle: drive, predict, check handshake, clock, check outputs
    task automatic step(input bit be, input bit fs, input bit vld);
        bit nb = 0;
        bit rdy = 0;
        bit uf_new = 0;
        rnd = rnd * 32'd1103515245 + 32'd12345;
        bit_en = be; frame_start = fs; in_valid = vld; in_data = rnd;
        rx_pin = gcyc[2];
        #1;
        if (be) begin
            if (fs) pos = 0;
            else if (pos >= 0) pos++;
            if (pos >= 0) begin
                int bits = int'(cfg_slot_bits_m1) + 1;
                int sb = (int'(cfg_size_code) + 1) * 4;
                int q = pos - int'(cfg_offset);
                if (q >= 0 && (q / bits) <= int'(cfg_slots_m1)) begin
                    int s = q / bits;
                    int b = q % bits;
                    bit en = eff_mask()[s];
                    if (en && b == 0) begin
                        rdy = 1;
                        if (vld) begin have = 1; cur = in_data; end
                        else begin have = 0; uf_new = 1; end
                    end
                    if (en && have && b < sb) nb = cur[sb-1-b];
                end
            end
        end
        // R7 R5: request only at the start of an enabled slot
        check(in_ready === rdy, "R7", int'(in_ready), int'(rdy));
        // R9: receive line selection
        check(rx_data === (cfg_loopback ? sdata : rx_pin), "R9", int'(rx_data),
              int'(cfg_loopback ? sdata : rx_pin));
        @(posedge clk);
        @(negedge clk);
        gcyc++;
        if (be) begin
            exp_sd = nb;
            if (uf_new) uf_exp = 1;
        end
        // R2 R3 R4 R10: serial bit against the model
        check(sdata === exp_sd, "R4", int'(sdata), int'(exp_sd));
        // R8: sticky starvation flag
        check(underflow === uf_exp, "R8", int'(underflow), int'(uf_exp));
    endtask

    // Run nb bit periods of `period` cycles; optional restart and stray pulse
    task automatic run_frame(input int nb, input int period, input int vmod,
                             input int vphase, input int restart_at, input bit stray);
        for (int j = 0; j < nb; j++) begin
            for (int c = 0; c < period; c++) begin
                bit be = (c == 0);
                bit fs = be ? ((j == 0) || (j == restart_at)) : (stray && j == 5 && c == 1);
                bit vld = (vmod == 0) ? 1'b1 : ((gcyc % vmod) != vphase);
                step(be, fs, vld);
            end
        end
    endtask

    initial begin
        bit_en = 0; frame_start = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(sdata === 1'b0, "R1", int'(sdata), 0);
        check(in_ready === 1'b0, "R1", int'(in_ready), 0);
        check(underflow === 1'b0, "R1", int'(underflow), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5: 4 slots of 16, 16-bit samples, offset 1, mask 1011b
        cfg_slots_m1 = 4'd3; cfg_slot_bits_m1 = 6'd15; cfg_size_code = 3'd3;
        cfg_offset = 11'd1; cfg_mask_req = 32'h0000_000B;
        run_frame(1 + 64 + 4, 1, 0, 0, -1, 0);

        // R4 R10: 8-bit samples in 16-bit slots, offset 0, bit_en every 3rd cycle, stray pulse
        cfg_slots_m1 = 4'd2; cfg_slot_bits_m1 = 6'd15; cfg_size_code = 3'd1;
        cfg_offset = 11'd0; cfg_mask_req = 32'h0000_0005; cfg_loopback = 1'b1;
        run_frame(48 + 4, 3, 0, 0, -1, 1);

        // R2: right-justified style offset 8, 8-bit sample, 16-bit slots
        cfg_slots_m1 = 4'd1; cfg_slot_bits_m1 = 6'd15; cfg_size_code = 3'd1;
        cfg_offset = 11'd8; cfg_mask_req = 32'h0000_0003; cfg_loopback = 1'b0;
        run_frame(8 + 32 + 4, 2, 0, 0, -1, 0);

        // R6 R3: 16 slots of 8 bits, 8-bit samples, saturated mask request
        cfg_slots_m1 = 4'd15; cfg_slot_bits_m1 = 6'd7; cfg_size_code = 3'd1;
        cfg_offset = 11'd0; cfg_mask_req = 32'h0003_0000;
        run_frame(128 + 4, 1, 0, 0, -1, 0);

        // R4: 32-bit samples in 36-bit slots, two slots
        cfg_slots_m1 = 4'd1; cfg_slot_bits_m1 = 6'd35; cfg_size_code = 3'd7;
        cfg_offset = 11'd2; cfg_mask_req = 32'h0000_0002; cfg_loopback = 1'b1;
        run_frame(2 + 72 + 4, 1, 0, 0, -1, 0);

        // R8 R11: intermittent stream, restart exactly on a slot boundary
        cfg_slots_m1 = 4'd5; cfg_slot_bits_m1 = 6'd7; cfg_size_code = 3'd1;
        cfg_offset = 11'd0; cfg_mask_req = 32'h0000_003D; cfg_loopback = 1'b0;
        run_frame(16 + 48 + 4, 1, 3, 1, 16, 0);

        // R8: flag stays set through a fully fed frame
        cfg_mask_req = 32'h0000_FFFF;
        run_frame(48 + 4, 1, 0, 0, -1, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule